// File: doc/BRIEF.md
# Chip-Select Timing Generator

This block frames SPI transactions for up to five attached slave ports. It stores one timing word per port (bit rate, setup count, hold count and rest count) and one shared port-state word that carries the port selector together with per-port idle levels for chip select, data, serial clock polarity and clock phase. A transfer sequencer asks for a frame with a valid/ready start handshake. The block then drives the chip select of the chosen port to its active level, waits out the setup count, and grants serial clocking. When the sequencer marks the last clock edge, the block withdraws the grant, waits out the hold count, releases chip select, and enforces a rest time before it takes the next start.

Between bytes the sequencer may request an optional pause in clocking. The pause reuses the hold count of the active port. The serial shifter sits outside this block. It consumes `clk_grant`, the selected clock polarity and phase, the data idle level and the bit rate. All counts are in periods of `clk`.

Back-pressure rules for the start handshake: a start is taken on a rising edge where both `start_valid` and `start_ready` are high. `start_valid` must stay high until that edge. `start_ready` is low for the whole of a frame, during most of the rest time, and whenever the selector names no port.

Top module: `cs_timing_gen`

## Requirements
- R1: After reset every chip-select output is high, `clk_grant` is low, `start_ready` is high (selector 0), and every port's chip-select idle level reads as high.
- R2: Port p takes its chip-select idle level from port-state bit 9-p and its data idle level from bit 4-p (port 0 at the highest bit of each group). While no frame is open, each `cs_out[p]` equals that port's idle level. `data_idle` shows the data idle level of the port chosen by selector bits 22:20.
- R3: For the selected port, `sclk_idle` is port-state bit 19-p and `sclk_phase` is bit 14-p. The pair {idle, phase} gives SPI mode 0 to 3: mode 1 sets phase only, mode 2 sets idle only, and mode 3 sets both.
- R4: On an accepted start, the selected port's chip select moves to the inverse of its idle level in the next cycle. Every other port stays at its idle level, and no more than one port is ever away from its idle level.
- R5: With setup count S (timing-word bits 23:16), chip select is active for exactly S+1 cycles before the first cycle with `clk_grant` high.
- R6: After `xfer_end` is sampled during a grant cycle, `clk_grant` is low from the next cycle on. Chip select then stays active for exactly H+1 cycles, where H is the hold count (bits 15:8). A hold count of 0 therefore still leaves one cycle.
- R7: With rest count D (bits 7:0) and a start waiting, chip select stays inactive for exactly D+1 cycles between frames. `start_ready` is never high while chip select is active.
- R8: With `gap_en` high, a `byte_end` pulse during a grant removes the grant for exactly H+1 cycles while chip select stays active. With `gap_en` low, `byte_end` leaves the grant high.
- R9: A selector value of 5, 6 or 7 holds `start_ready` low. No chip select leaves its idle level while that value is in place.
- R10: A timing word written with `param_we` lands in the port named by `param_port`. `bit_rate` shows bits 31:24 of the selected port's word.
- R11: When `xfer_end` and `byte_end` arrive together, the frame ends as in R6 and no gap is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| param_we | input | 1 | Write strobe for a per-port timing word |
| param_port | input | 3 | Port whose timing word is written |
| param_wdata | input | 32 | Timing word: rate 31:24, setup 23:16, hold 15:8, rest 7:0 |
| state_we | input | 1 | Write strobe for the port-state word |
| state_wdata | input | 32 | Port-state word: selector 22:20, clock idle 19:15, phase 14:10, cs idle 9:5, data idle 4:0 |
| start_valid | input | 1 | Sequencer requests a new frame |
| start_ready | output | 1 | Block can accept a frame now |
| gap_en | input | 1 | Enables the pause between bytes |
| byte_end | input | 1 | Pulse: a byte finished and more follow |
| xfer_end | input | 1 | Pulse: the last clock edge of the frame happened |
| clk_grant | output | 1 | Serial clocking is permitted |
| cs_out | output | 5 | Chip-select levels, one per port |
| sclk_idle | output | 1 | Clock idle level of the selected port |
| sclk_phase | output | 1 | Clock phase of the selected port |
| data_idle | output | 1 | Data idle level of the selected port |
| bit_rate | output | 8 | Rate field of the selected port |

## Verification
A counter that loads or leaves its phase one cycle early or late shows up at once as a setup, hold, gap or rest window one cycle off. The bench measures each of these windows cycle by cycle. A lost or wrong latched port shows within one cycle of acceptance as the wrong `cs_out` bit moving, or two bits away from idle. A mis-ordered idle-level group shows on `cs_out`, `data_idle`, `sclk_idle` or `sclk_phase` in the cycle after the port-state write. A state machine that skips its hold phase shows as chip select falling in the same cycle the grant drops.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

  // Port-state word layout: top bit of each five-bit group belongs to port 0
  localparam int SEL_LSB     = 20;
  localparam int SEL_W       = 3;
  localparam int CKIDLE_TOP  = 19;
  localparam int PHASE_TOP   = 14;
  localparam int CSIDLE_TOP  = 9;
  localparam int DIDLE_TOP   = 4;
  localparam int WORD_W      = 32;
  localparam int CNT_W       = 8;

  // Per-port timing word, packed so the field order matches the bit layout
  typedef struct packed {
    logic [CNT_W-1:0] rate;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] rest;
  } port_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_GAP,
    ST_HOLD,
    ST_REST
  } frame_state_e;

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import cs_timing_pkg::*;
#(
  parameter int N_PORTS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                param_we,
  input  logic [SEL_W-1:0]    param_port,
  input  logic [WORD_W-1:0]   param_wdata,
  input  logic                state_we,
  input  logic [WORD_W-1:0]   state_wdata,
  input  logic [SEL_W-1:0]    act_port,
  output logic [SEL_W-1:0]    port_sel,
  output logic                sel_ok,
  output logic [N_PORTS-1:0]  cs_idle,
  output port_timing_t        sel_timing,
  output port_timing_t        act_timing,
  output logic                sclk_idle,
  output logic                sclk_phase,
  output logic                data_idle
);

  // Reset value: every chip select idles high, all else zero
  localparam logic [WORD_W-1:0] STATE_RST =
    WORD_W'({N_PORTS{1'b1}}) << (CSIDLE_TOP - N_PORTS + 1);

  logic [WORD_W-1:0]           state_q;
  port_timing_t [N_PORTS-1:0]  prm_vec;
  logic [N_PORTS-1:0]          ck_idle_v;
  logic [N_PORTS-1:0]          phase_v;
  logic [N_PORTS-1:0]          d_idle_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= STATE_RST;
    else if (state_we) state_q <= state_wdata;
  end

  assign port_sel = state_q[SEL_LSB +: SEL_W];
  assign sel_ok   = int'(port_sel) < N_PORTS;

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_port
    port_timing_t prm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prm_q <= '0;
      else if (param_we && (param_port == SEL_W'(gp)))
        prm_q <= port_timing_t'(param_wdata);
    end
    assign prm_vec[gp]   = prm_q;
    // Bit order inside each group runs opposite to the port index
    assign cs_idle[gp]   = state_q[CSIDLE_TOP - gp];
    assign ck_idle_v[gp] = state_q[CKIDLE_TOP - gp];
    assign phase_v[gp]   = state_q[PHASE_TOP  - gp];
    assign d_idle_v[gp]  = state_q[DIDLE_TOP  - gp];
  end

  always_comb begin
    sel_timing = '0;
    act_timing = '0;
    sclk_idle  = 1'b0;
    sclk_phase = 1'b0;
    data_idle  = 1'b0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (port_sel == SEL_W'(i)) begin
        sel_timing = prm_vec[i];
        sclk_idle  = ck_idle_v[i];
        sclk_phase = phase_v[i];
        data_idle  = d_idle_v[i];
      end
      if (act_port == SEL_W'(i)) act_timing = prm_vec[i];
    end
  end

endmodule

// File: rtl/cs_frame_fsm.sv
module cs_frame_fsm
  import cs_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [SEL_W-1:0]  port_sel,
  input  logic              sel_ok,
  input  logic [CNT_W-1:0]  setup_cnt,
  input  logic [CNT_W-1:0]  hold_cnt,
  input  logic [CNT_W-1:0]  rest_cnt,
  input  logic              gap_en,
  input  logic              byte_end,
  input  logic              xfer_end,
  output logic              start_ready,
  output logic [SEL_W-1:0]  act_port,
  output logic              cs_active,
  output logic              clk_grant
);

  frame_state_e      st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_zero;
  logic              accept;

  assign cnt_zero    = (cnt_q == '0);
  // Ready in idle, and already in the final cycle of the rest window
  assign start_ready = sel_ok && ((st_q == ST_IDLE) ||
                                  ((st_q == ST_REST) && cnt_zero));
  assign accept      = start_valid && start_ready;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_SETUP;
          cnt_d = setup_cnt;
        end
      end
      ST_SETUP: begin
        if (cnt_zero) st_d = ST_RUN;
        else          cnt_d = cnt_q - 1'b1;
      end
      ST_RUN: begin
        if (xfer_end) begin
          st_d  = ST_HOLD;
          cnt_d = hold_cnt;
        end else if (byte_end && gap_en) begin
          st_d  = ST_GAP;
          cnt_d = hold_cnt;
        end
      end
      ST_GAP: begin
        if (cnt_zero) st_d = ST_RUN;
        else          cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          st_d  = ST_REST;
          cnt_d = rest_cnt;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_REST: begin
        if (accept) begin
          st_d  = ST_SETUP;
          cnt_d = setup_cnt;
        end else if (cnt_zero) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      act_port <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept) act_port <= port_sel;
    end
  end

  assign cs_active = (st_q == ST_SETUP) || (st_q == ST_RUN) ||
                     (st_q == ST_GAP)   || (st_q == ST_HOLD);
  assign clk_grant = (st_q == ST_RUN);

endmodule

// File: rtl/cs_level_map.sv
module cs_level_map
  import cs_timing_pkg::*;
#(
  parameter int N_PORTS = 5
) (
  input  logic [N_PORTS-1:0] cs_idle,
  input  logic [SEL_W-1:0]   act_port,
  input  logic               cs_active,
  output logic [N_PORTS-1:0] cs_out
);

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_cs
    logic drive;
    assign drive      = cs_active && (act_port == SEL_W'(gp));
    assign cs_out[gp] = drive ? ~cs_idle[gp] : cs_idle[gp];
  end

endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
  import cs_timing_pkg::*;
#(
  parameter int N_PORTS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                param_we,
  input  logic [2:0]          param_port,
  input  logic [31:0]         param_wdata,
  input  logic                state_we,
  input  logic [31:0]         state_wdata,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic                gap_en,
  input  logic                byte_end,
  input  logic                xfer_end,
  output logic                clk_grant,
  output logic [N_PORTS-1:0]  cs_out,
  output logic                sclk_idle,
  output logic                sclk_phase,
  output logic                data_idle,
  output logic [7:0]          bit_rate
);

  logic [SEL_W-1:0]    port_sel_w;
  logic [SEL_W-1:0]    act_port_w;
  logic                sel_ok_w;
  logic                cs_active_w;
  logic [N_PORTS-1:0]  cs_idle_w;
  port_timing_t        sel_timing_w;
  port_timing_t        act_timing_w;

  cs_cfg_bank #(.N_PORTS(N_PORTS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .param_we    (param_we),
    .param_port  (param_port),
    .param_wdata (param_wdata),
    .state_we    (state_we),
    .state_wdata (state_wdata),
    .act_port    (act_port_w),
    .port_sel    (port_sel_w),
    .sel_ok      (sel_ok_w),
    .cs_idle     (cs_idle_w),
    .sel_timing  (sel_timing_w),
    .act_timing  (act_timing_w),
    .sclk_idle   (sclk_idle),
    .sclk_phase  (sclk_phase),
    .data_idle   (data_idle)
  );

  cs_frame_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .port_sel    (port_sel_w),
    .sel_ok      (sel_ok_w),
    .setup_cnt   (sel_timing_w.setup),
    .hold_cnt    (act_timing_w.hold),
    .rest_cnt    (act_timing_w.rest),
    .gap_en      (gap_en),
    .byte_end    (byte_end),
    .xfer_end    (xfer_end),
    .start_ready (start_ready),
    .act_port    (act_port_w),
    .cs_active   (cs_active_w),
    .clk_grant   (clk_grant)
  );

  cs_level_map #(.N_PORTS(N_PORTS)) u_map (
    .cs_idle   (cs_idle_w),
    .act_port  (act_port_w),
    .cs_active (cs_active_w),
    .cs_out    (cs_out)
  );

  assign bit_rate = sel_timing_w.rate;

endmodule

// File: rtl/cs_timing_chk.sv
module cs_timing_chk #(
  parameter int N_PORTS = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] cs_out,
  input logic [N_PORTS-1:0] cs_idle,
  input logic               cs_active,
  input logic               clk_grant,
  input logic               start_ready,
  input logic               sel_ok
);

  AST_ONE_PORT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_out ^ cs_idle) <= 1);  // R4

  AST_GRANT_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_grant |-> cs_active);  // R5

  AST_SETUP_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_active) |-> !clk_grant);  // R5

  AST_HOLD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_active) |-> !$past(clk_grant));  // R6

  AST_READY_WHILE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !cs_active);  // R7

  AST_BAD_SEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> !start_ready);  // R9

endmodule

bind cs_timing_gen cs_timing_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_out      (cs_out),
  .cs_idle     (cs_idle_w),
  .cs_active   (cs_active_w),
  .clk_grant   (clk_grant),
  .start_ready (start_ready),
  .sel_ok      (sel_ok_w)
);

// File: tb/cs_timing_gen_bench.sv
module cs_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        param_we = 1'b0;
  logic [2:0]  param_port = '0;
  logic [31:0] param_wdata = '0;
  logic        state_we = 1'b0;
  logic [31:0] state_wdata = '0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic        gap_en = 1'b0;
  logic        byte_end = 1'b0;
  logic        xfer_end = 1'b0;
  logic        clk_grant;
  logic [4:0]  cs_out;
  logic        sclk_idle;
  logic        sclk_phase;
  logic        data_idle;
  logic [7:0]  bit_rate;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cs_timing_gen u_cs_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .param_we(param_we), .param_port(param_port), .param_wdata(param_wdata),
    .state_we(state_we), .state_wdata(state_wdata),
    .start_valid(start_valid), .start_ready(start_ready),
    .gap_en(gap_en), .byte_end(byte_end), .xfer_end(xfer_end),
    .clk_grant(clk_grant), .cs_out(cs_out),
    .sclk_idle(sclk_idle), .sclk_phase(sclk_phase),
    .data_idle(data_idle), .bit_rate(bit_rate)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-port vector (index = port) into a group with port 0 at the top bit
  function automatic logic [4:0] grp(logic [4:0] v);
    logic [4:0] g;
    for (int p = 0; p < 5; p++) g[4-p] = v[p];
    return g;
  endfunction

  function automatic logic [31:0] mk_state(logic [2:0] sel, logic [4:0] ck,
                                           logic [4:0] ph, logic [4:0] cs,
                                           logic [4:0] di);
    return {9'b0, sel, grp(ck), grp(ph), grp(cs), grp(di)};
  endfunction

  task automatic wr_param(int p, logic [31:0] w);
    @(negedge clk);
    param_we = 1'b1; param_port = 3'(p); param_wdata = w;
    @(negedge clk);
    param_we = 1'b0;
  endtask

  task automatic wr_state(logic [31:0] w);
    @(negedge clk);
    state_we = 1'b1; state_wdata = w;
    @(negedge clk);
    state_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !start_ready; i++) @(negedge clk);
  endtask

  task automatic finish_frame();
    for (int i = 0; i < 1000 && !clk_grant; i++) @(negedge clk);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    wait_ready();
  endtask

  task automatic t_reset();
    chk("R1 cs_out", 32'(cs_out), 32'h1F);
    chk("R1 clk_grant", 32'(clk_grant), 0);
    chk("R1 start_ready", 32'(start_ready), 1);
  endtask

  task automatic t_levels();
    wr_state(mk_state(3'd2, 5'b00000, 5'b00000, 5'b10010, 5'b00100));
    chk("R2 idle cs levels", 32'(cs_out), 32'h12);
    chk("R2 data idle port2", 32'(data_idle), 1);
    wr_state(mk_state(3'd1, 5'b00000, 5'b00010, 5'b10010, 5'b00100));
    chk("R2 data idle port1", 32'(data_idle), 0);
    chk("R3 mode1", 32'({sclk_idle, sclk_phase}), 1);
    wr_state(mk_state(3'd3, 5'b01000, 5'b01000, 5'b11111, 5'b0));
    chk("R3 mode3", 32'({sclk_idle, sclk_phase}), 3);
    wr_state(mk_state(3'd2, 5'b00100, 5'b01000, 5'b11111, 5'b0));
    chk("R3 mode2", 32'({sclk_idle, sclk_phase}), 2);
  endtask

  task automatic t_rate();
    wr_param(3, 32'h2A000000);
    wr_param(0, 32'h11000000);
    wr_state(mk_state(3'd3, 5'b0, 5'b0, 5'b11111, 5'b0));
    chk("R10 rate port3", 32'(bit_rate), 32'h2A);
    wr_state(mk_state(3'd0, 5'b0, 5'b0, 5'b11111, 5'b0));
    chk("R10 rate port0", 32'(bit_rate), 32'h11);
  endtask

  task automatic t_frame(int p, int s, int h, int d);
    int n;
    wr_param(p, {8'h01, 8'(s), 8'(h), 8'(d)});
    wr_state(mk_state(3'(p), 5'b0, 5'b0, 5'b11111, 5'b0));
    wait_ready();
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk($sformatf("R4 port%0d active", p), 32'(cs_out), 32'(5'h1F & ~(5'd1 << p)));
    n = 0;
    while (!clk_grant && n < 1000) begin n++; @(negedge clk); end
    chk($sformatf("R5 setup S=%0d", s), n, s + 1);
    repeat (2) @(negedge clk);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    chk("R6 grant off", 32'(clk_grant), 0);
    n = 0;
    while (cs_out[p] == 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk($sformatf("R6 hold H=%0d", h), n, h + 1);
    start_valid = 1'b1;
    n = 0;
    while (cs_out[p] == 1'b1 && n < 1000) begin n++; @(negedge clk); end
    start_valid = 1'b0;
    chk($sformatf("R7 rest D=%0d", d), n, d + 1);
    finish_frame();
  endtask

  task automatic t_active_high();
    wr_param(1, 32'h01010101);
    wr_state(mk_state(3'd1, 5'b0, 5'b0, 5'b11101, 5'b0));
    wait_ready();
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk("R4 idle-low port drives high", 32'(cs_out), 32'h1F);
    finish_frame();
    chk("R2 idle-low port back low", 32'(cs_out), 32'h1D);
  endtask

  task automatic t_gap();
    int n;
    bit seen;
    wr_param(0, {8'h01, 8'd0, 8'd2, 8'd0});
    wr_state(mk_state(3'd0, 5'b0, 5'b0, 5'b11111, 5'b0));
    wait_ready();
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    for (int i = 0; i < 1000 && !clk_grant; i++) @(negedge clk);
    gap_en = 1'b1; byte_end = 1'b1;
    @(negedge clk);
    byte_end = 1'b0;
    n = 0;
    while (!clk_grant && n < 1000) begin n++; @(negedge clk); end
    chk("R8 gap length", n, 3);
    chk("R8 cs held in gap", 32'(cs_out[0]), 0);
    gap_en = 1'b0; byte_end = 1'b1;
    @(negedge clk);
    byte_end = 1'b0;
    chk("R8 no gap when disabled", 32'(clk_grant), 1);
    gap_en = 1'b1; byte_end = 1'b1; xfer_end = 1'b1;
    @(negedge clk);
    byte_end = 1'b0; xfer_end = 1'b0;
    n = 0; seen = 1'b0;
    while (cs_out[0] == 1'b0 && n < 1000) begin
      if (clk_grant) seen = 1'b1;
      n++; @(negedge clk);
    end
    gap_en = 1'b0;
    chk("R11 end wins hold", n, 3);
    chk("R11 no regrant", 32'(seen), 0);
    wait_ready();
  endtask

  task automatic t_badsel();
    wr_state(mk_state(3'd5, 5'b0, 5'b0, 5'b11111, 5'b0));
    chk("R9 ready low", 32'(start_ready), 0);
    start_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 no cs", 32'(cs_out), 32'h1F);
    chk("R9 no grant", 32'(clk_grant), 0);
    start_valid = 1'b0;
    wr_state(mk_state(3'd0, 5'b0, 5'b0, 5'b11111, 5'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_rate();
    t_frame(0, 3, 2, 4);
    t_frame(4, 0, 0, 0);
    t_frame(2, 5, 7, 1);
    t_active_high();
    t_gap();
    t_badsel();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule